// File: doc/BRIEF.md
# Security module bring-up and locality claim sequencer

After reset the attached security module has to be identified and locality 0 claimed before any command can be sent to it. This block runs that bring-up once for each `start` pulse. It issues register transactions through a request port to a separate transaction master, which performs the serial transfers. Each request carries a direction, a 24-bit address, a byte length and one write byte. Read data comes back as a byte stream, and each transaction ends with a completion pulse that carries a success flag.

The order of steps is fixed:

1. Read the 32-bit identification word.
2. Read the access register. If it shows the locality already active, release it once and read the register again.
3. Check that the register is valid and the locality free, ignoring the establishment flag.
4. Request use and confirm that the locality became active.
5. Check the interface family field of the status register.
6. Read the one-byte revision.

The block then reports done, or reports fail with a code that names the step that went wrong. The vendor ID, device ID and revision are held on the outputs.

Top module: `secinit_seq`

## Requirements
- R1: After reset, and until the first `start`, `done`, `fail`, `busy` and `req_valid` are 0, and `fail_code`, `vendor_id`, `device_id` and `revision` are 0.
- R2: The first request after `start` is a 4-byte read of address 0xD40F00. If that transaction completes with `xfer_ok`=0, the block ends in fail with `fail_code`=1 and issues no further request.
- R3: The access register is read as 1 byte at 0xD40000. If bit 5 (active) of the value is set, the block writes 0x20 to 0xD40000 and reads the register again. Otherwise no write of 0x20 is issued.
- R4: The latest access value, with bit 0 (establishment) masked, must equal 0x80 (bit 7 valid only). Otherwise the block fails with `fail_code`=2.
- R5: The block then writes 0x02 to 0xD40000 and reads the register again. The value, with bit 0 masked, must equal 0xA0. Otherwise the block fails with `fail_code`=3.
- R6: The block reads 4 bytes at 0xD40018. Bits 27:26 of that word must equal 1. Otherwise the block fails with `fail_code`=4.
- R7: The block reads 1 byte at 0xD40F04 and then ends in done with `fail_code`=0. `vendor_id` is bits 15:0 of the identification word and `device_id` is bits 31:16. `revision` is the revision byte. Multi-byte values are assembled little-endian: the first byte received is bits 7:0.
- R8: `req_valid` and the request fields stay stable until `req_ready` is seen. Only one transaction is outstanding at a time. Every write has length 1.
- R9: `done` and `fail` hold until the next `start`. A `start` while `busy` is 1 has no effect on the running sequence.
- R10: `done` and `fail` are never both 1. `fail_code` is nonzero exactly when `fail` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up sequence (ignored while busy) |
| req_valid | output | 1 | Transaction request pending |
| req_ready | input | 1 | Master accepts the request this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 24 | Register address |
| req_len | output | 7 | Transfer length in bytes |
| req_wdata | output | 8 | Byte to write |
| rd_valid | input | 1 | A read data byte is present |
| rd_byte | input | 8 | Read data byte |
| xfer_done | input | 1 | Transaction completed (after its last byte) |
| xfer_ok | input | 1 | Completed transaction succeeded |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence ended successfully |
| fail | output | 1 | Sequence ended in failure |
| fail_code | output | 3 | 0 none, 1 ID transfer, 2 locality not free, 3 claim refused, 4 wrong family |
| vendor_id | output | 16 | Captured vendor ID |
| device_id | output | 16 | Captured device ID |
| revision | output | 8 | Captured revision |

## Verification
The hardest path to reach from the ports is the release-and-retry branch, in both of its outcomes. It needs the locality to read as already active, and then the release write to either free the locality or leave it stuck. A responder model in the bench keeps a live access register that reacts to the release and request writes. The bench sweeps every combination of these:

- the valid flag
- the initial active flag
- the establishment flag
- whether the release works
- whether the claim works
- all four family values
- a failing first transfer

For each combination the bench predicts the final code, the number of transactions and the number of release writes.

// File: rtl/secinit_pkg.sv
package secinit_pkg;
    localparam int ADDR_W     = 24;
    localparam int LEN_W      = 7;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;

    localparam logic [ADDR_W-1:0] LOC0_BASE = 24'hD40000;
    localparam logic [ADDR_W-1:0] OFS_ACC   = 24'h000000;
    localparam logic [ADDR_W-1:0] OFS_STS   = 24'h000018;
    localparam logic [ADDR_W-1:0] OFS_IDW   = 24'h000F00;
    localparam logic [ADDR_W-1:0] OFS_REV   = 24'h000F04;

    localparam logic [7:0] ACC_VALID  = 8'h80;
    localparam logic [7:0] ACC_ACTIVE = 8'h20;
    localparam logic [7:0] ACC_REQ    = 8'h02;
    localparam logic [7:0] ACC_ESTMSK = 8'hFE;
    localparam logic [1:0] FAMILY_G2  = 2'd1;

    typedef enum logic [3:0] {
        S_IDLE, S_ID, S_ACC1, S_REL, S_ACC2, S_REQ, S_ACC3, S_STS, S_RID, S_DONE, S_FAIL
    } step_e;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0, FC_IDXFER = 3'd1, FC_LOCBUSY = 3'd2, FC_CLAIM = 3'd3, FC_FAMILY = 3'd4
    } fcode_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [7:0]        wdata;
    } req_t;

    function automatic logic step_is_txn(step_e s);
        return (s != S_IDLE) && (s != S_DONE) && (s != S_FAIL);
    endfunction
endpackage

// File: rtl/secinit_pack.sv
module secinit_pack #(
    parameter int NBYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_vld,
    input  logic [7:0]          in_byte,
    output logic [8*NBYTES-1:0] word
);
    localparam int IDX_W = $clog2(NBYTES + 1);

    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        idx_d = idx_q;
        if (clr) begin
            idx_d = '0;
        end else if (in_vld && (idx_q < IDX_W'(NBYTES))) begin
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [7:0] lane_q, lane_d;
        always_comb begin
            lane_d = lane_q;
            if (clr) lane_d = '0;
            else if (in_vld && (idx_q == IDX_W'(g))) lane_d = in_byte;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end
        assign word[8*g +: 8] = lane_q;
    end
endmodule

// File: rtl/secinit_req.sv
module secinit_req
    import secinit_pkg::*;
(
    input  step_e step,
    output req_t  req
);
    always_comb begin
        req = '{write: 1'b0, addr: LOC0_BASE + OFS_ACC, len: LEN_W'(1), wdata: 8'h00};
        unique case (step)
            S_ID:  begin req.addr = LOC0_BASE + OFS_IDW; req.len = LEN_W'(WORD_BYTES); end
            S_REL: begin req.write = 1'b1; req.wdata = ACC_ACTIVE; end
            S_REQ: begin req.write = 1'b1; req.wdata = ACC_REQ; end
            S_STS: begin req.addr = LOC0_BASE + OFS_STS; req.len = LEN_W'(WORD_BYTES); end
            S_RID: req.addr = LOC0_BASE + OFS_REV;
            default: ;
        endcase
    end
endmodule

// File: rtl/secinit_seq.sv
module secinit_seq
    import secinit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [7:0]        req_wdata,
    input  logic              rd_valid,
    input  logic [7:0]        rd_byte,
    input  logic              xfer_done,
    input  logic              xfer_ok,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [2:0]        fail_code,
    output logic [15:0]       vendor_id,
    output logic [15:0]       device_id,
    output logic [7:0]        revision
);
    typedef struct packed {
        step_e       step;
        logic        wait_rsp;
        logic        done;
        logic        fail;
        fcode_e      code;
        logic [15:0] vid;
        logic [15:0] did;
        logic [7:0]  rev;
    } ctl_t;

    ctl_t s_q, s_d;
    req_t req;
    logic [WORD_W-1:0] word;
    logic accept;
    logic acc_free, acc_claimed, fam_ok;

    secinit_req u_req (.step(s_q.step), .req(req));

    secinit_pack #(.NBYTES(WORD_BYTES)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .in_vld(rd_valid), .in_byte(rd_byte), .word(word)
    );

    assign busy      = step_is_txn(s_q.step);
    assign req_valid = busy && !s_q.wait_rsp;
    assign accept    = req_valid && req_ready;
    assign req_write = req.write;
    assign req_addr  = req.addr;
    assign req_len   = req.len;
    assign req_wdata = req.wdata;

    assign acc_free    = (word[7:0] & ACC_ESTMSK) == ACC_VALID;
    assign acc_claimed = (word[7:0] & ACC_ESTMSK) == (ACC_VALID | ACC_ACTIVE);
    assign fam_ok      = word[27:26] == FAMILY_G2;

    always_comb begin
        s_d = s_q;
        if (!busy) begin
            if (start) begin
                s_d.step     = S_ID;
                s_d.wait_rsp = 1'b0;
                s_d.done     = 1'b0;
                s_d.fail     = 1'b0;
                s_d.code     = FC_NONE;
            end
        end else if (!s_q.wait_rsp) begin
            if (req_ready) s_d.wait_rsp = 1'b1;
        end else if (xfer_done) begin
            s_d.wait_rsp = 1'b0;
            unique case (s_q.step)
                S_ID: begin
                    if (!xfer_ok) begin
                        s_d.step = S_FAIL; s_d.code = FC_IDXFER;
                    end else begin
                        s_d.vid  = word[15:0];
                        s_d.did  = word[31:16];
                        s_d.step = S_ACC1;
                    end
                end
                S_ACC1: begin
                    if ((word[7:0] & ACC_ACTIVE) != 8'h00) s_d.step = S_REL;
                    else if (acc_free)                     s_d.step = S_REQ;
                    else begin s_d.step = S_FAIL; s_d.code = FC_LOCBUSY; end
                end
                S_REL: s_d.step = S_ACC2;
                S_ACC2: begin
                    if (acc_free) s_d.step = S_REQ;
                    else begin s_d.step = S_FAIL; s_d.code = FC_LOCBUSY; end
                end
                S_REQ: s_d.step = S_ACC3;
                S_ACC3: begin
                    if (acc_claimed) s_d.step = S_STS;
                    else begin s_d.step = S_FAIL; s_d.code = FC_CLAIM; end
                end
                S_STS: begin
                    if (fam_ok) s_d.step = S_RID;
                    else begin s_d.step = S_FAIL; s_d.code = FC_FAMILY; end
                end
                S_RID: begin
                    s_d.rev  = word[7:0];
                    s_d.step = S_DONE;
                end
                default: ;
            endcase
            if (s_d.step == S_DONE) s_d.done = 1'b1;
            if (s_d.step == S_FAIL) s_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{step: S_IDLE, wait_rsp: 1'b0, done: 1'b0, fail: 1'b0,
                     code: FC_NONE, vid: '0, did: '0, rev: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done      = s_q.done;
    assign fail      = s_q.fail;
    assign fail_code = s_q.code;
    assign vendor_id = s_q.vid;
    assign device_id = s_q.did;
    assign revision  = s_q.rev;
endmodule

// File: rtl/secinit_chk.sv
module secinit_chk
    import secinit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic [7:0]        req_wdata,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [2:0]        fail_code
);
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
                                    && $stable(req_len) && $stable(req_wdata));

    a_r8_write_len: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |-> req_len == LEN_W'(1) && req_addr == LOC0_BASE + OFS_ACC);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    a_r10_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_code != 3'd0) == fail);

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !start |=> fail && $stable(fail_code));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);
endmodule

bind secinit_seq secinit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .done(done), .fail(fail), .fail_code(fail_code)
);

// File: tb/sim_secinit_seq.sv
`timescale 1ns/1ps
module sim_secinit_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [23:0] req_addr;
    logic [6:0]  req_len;
    logic [7:0]  req_wdata;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_byte = 8'h00;
    logic        xfer_done = 1'b0;
    logic        xfer_ok = 1'b0;
    logic        busy, done, fail;
    logic [2:0]  fail_code;
    logic [15:0] vendor_id, device_id;
    logic [7:0]  revision;

    always #10 clk = ~clk;

    secinit_seq u0 (.*);

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // responder configuration and model state
    logic        c_vld, c_act, c_est, c_rel, c_claim, c_idfail;
    logic [1:0]  c_fam;
    logic [31:0] c_id;
    logic [7:0]  c_rid;
    logic        m_act;
    int          n_txn, n_rel, n_bad;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic responder();
        logic        w;
        logic [23:0] a;
        logic [6:0]  l;
        logic [7:0]  d;
        logic [31:0] v;
        forever begin
            @(negedge clk);
            if (req_valid) begin
                w = req_write; a = req_addr; l = req_len; d = req_wdata;
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                n_txn++;
                v = 32'h0;
                if (w) begin
                    if (a != 24'hD40000 || l != 7'd1) n_bad++;
                    if (d == 8'h20) begin n_rel++; if (c_rel) m_act = 1'b0; end
                    else if (d == 8'h02) m_act = c_claim;
                    else n_bad++;
                end else begin
                    case (a)
                        24'hD40F00: begin v = c_id; if (l != 7'd4) n_bad++; end
                        24'hD40000: begin v = {24'h0, c_vld, 1'b0, m_act, 4'h0, c_est}; if (l != 7'd1) n_bad++; end
                        24'hD40018: begin v = {4'h0, c_fam, 26'h0001490}; if (l != 7'd4) n_bad++; end
                        24'hD40F04: begin v = {24'h0, c_rid}; if (l != 7'd1) n_bad++; end
                        default: n_bad++;
                    endcase
                    for (int i = 0; i < int'(l); i++) begin
                        rd_valid = 1'b1;
                        rd_byte  = v[8*(i%4) +: 8];
                        @(negedge clk);
                    end
                    rd_valid = 1'b0;
                end
                @(negedge clk);
                xfer_done = 1'b1;
                xfer_ok   = !(c_idfail && a == 24'hD40F00 && !w);
                @(negedge clk);
                xfer_done = 1'b0;
                xfer_ok   = 1'b0;
            end
        end
    endtask

    task automatic run_case(input int k);
        int exp_code, exp_txn, exp_rel, t;
        logic act2;
        c_vld = k[0]; c_act = k[1]; c_est = k[2]; c_rel = k[3];
        c_claim = k[4]; c_fam = k[6:5]; c_idfail = k[7];
        c_id  = 32'h1357_9BDF ^ (k * 32'h0101_0F1D);
        c_rid = 8'h40 + 8'(k);
        m_act = c_act;
        n_txn = 0; n_rel = 0; n_bad = 0;

        // expected outcome from the requirements
        exp_rel = 0;
        if (c_idfail) begin
            exp_code = 1; exp_txn = 1;
        end else begin
            exp_txn = 2;
            act2 = c_act;
            if (c_act) begin exp_rel = 1; exp_txn += 2; act2 = !c_rel; end
            if (!(c_vld && !act2)) exp_code = 2;
            else begin
                exp_txn += 2;
                if (!(c_vld && c_claim)) exp_code = 3;
                else begin
                    exp_txn += 1;
                    if (c_fam != 2'd1) exp_code = 4;
                    else begin exp_txn += 1; exp_code = 0; end
                end
            end
        end

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;                     // R9: ignored while busy
        @(negedge clk); start = 1'b0;
        t = 0;
        while (!(done || fail) && t < 2000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);        // R9: result holds

        if (exp_code == 0) begin
            chk(done && !fail && fail_code == 0, "R7", "done/code", {done, fail, fail_code}, 5'b10000);
            chk(vendor_id == c_id[15:0], "R7", "vendor_id", vendor_id, c_id[15:0]);
            chk(device_id == c_id[31:16], "R7", "device_id", device_id, c_id[31:16]);
            chk(revision == c_rid, "R7", "revision", revision, c_rid);
        end else begin
            chk(fail && !done && int'(fail_code) == exp_code,
                exp_code == 1 ? "R2" : exp_code == 2 ? "R4" : exp_code == 3 ? "R5" : "R6",
                "fail_code", {done, fail, fail_code}, {2'b01, 3'(exp_code)});
        end
        chk(n_txn == exp_txn, "R9", "transaction count", n_txn, exp_txn);
        chk(n_rel == exp_rel, "R3", "release writes", n_rel, exp_rel);
        chk(n_bad == 0, "R8", "malformed requests", n_bad, 0);
        chk(!busy && !req_valid, "R10", "idle after end", {busy, req_valid}, 0);
    endtask

    initial begin
        fork
            responder();
            begin
                forever begin
                    @(posedge clk);
                    cycles++;
                    if (cycles > 150000) begin
                        checks++; errors++;
                        $display("FAIL watchdog actual=%0d expected=finish", cycles);
                        finish_run();
                    end
                end
            end
        join_none

        c_vld = 1; c_act = 0; c_est = 0; c_rel = 0; c_claim = 0; c_idfail = 0;
        c_fam = 0; c_id = 0; c_rid = 0; m_act = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(!done && !fail && !busy && !req_valid && fail_code == 0, "R1", "control outputs",
            {done, fail, busy, req_valid, fail_code}, 0);
        chk(vendor_id == 0 && device_id == 0 && revision == 0, "R1", "id outputs",
            {vendor_id, device_id, revision}, 0);

        for (int k = 0; k < 256; k++) run_case(k);
        finish_run();
    end
endmodule